// File: doc/BRIEF.md
# Per-Line Interrupt Vector Arbiter

This block gathers interrupt requests from up to sixteen serial lines in two classes, receive and transmit. Each class holds one pending bit per line and raises a master request whenever any enabled line in that class is pending. When the processor acknowledges a class, the block picks the lowest-numbered enabled line pending in that class and clears its bit. One cycle later it presents a vector. The vector sits 8 apart per line above a programmable base, and transmit vectors sit a further 4 above the receive vector of the same line.

A line-count input switches off the upper lines, so one design serves boards with fewer ports. A small state machine sequences the vector output. It has four states:

- IDLE: no vector is shown.
- RX_SHOW: a receive vector is shown.
- TX_SHOW: a transmit vector is shown.
- RX_SHOW_TX_WAIT: a receive vector is shown while a transmit acknowledge waits its turn.

The transitions are:

- From IDLE, RX_SHOW or TX_SHOW, on the clock edge:
  - TAKE_RX (receive acknowledge alone) leads to RX_SHOW.
  - TAKE_TX (transmit acknowledge alone) leads to TX_SHOW.
  - TAKE_BOTH (both acknowledges) leads to RX_SHOW_TX_WAIT.
  - DROP (no acknowledge) leads to IDLE.
- From RX_SHOW_TX_WAIT, the one transition is SERVE_QUEUED, which always leads to TX_SHOW.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Each class's master request (rx_irq, tx_irq) is high in the cycle after any enabled line of that class becomes pending. It stays high until every enabled pending bit of the class is cleared.
- R2: A one-cycle pulse on bit i of a set input makes line i pending in that class. A pulse on bit i of a clear input removes it. A set always wins over a clear or an acknowledge that targets the same bit in the same cycle.
- R3: An acknowledge of a class chooses the lowest-numbered enabled pending line of that class and clears its pending bit.
- R4: A receive vector equals vec_base + 8*line. A transmit vector equals vec_base + 8*line + 4. Both are taken modulo 2^VEC_W.
- R5: An acknowledge that finds no enabled pending line in its class returns vector 0, and vec_valid still pulses.
- R6: vec_out and vec_valid are registered. They present the result in the cycle after the acknowledge is sampled. vec_is_tx is 1 for a transmit vector and 0 for a receive vector, and vec_valid is low when no acknowledge was taken.
- R7: When both acknowledges arrive in one cycle, the receive vector is shown in the next cycle and the transmit vector in the cycle after. Acknowledges raised while the receive vector is shown with a transmit waiting are ignored.
- R8: Lines whose index is at or above active_lines (range 0 to 16) neither drive the master requests nor win an acknowledge. Their pending bits are kept and take part again once active_lines covers them.
- R9: After reset no line is pending, both master requests are low, vec_valid is low and vec_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_base | input | VEC_W | Base of the vector block |
| active_lines | input | ACT_W | Number of enabled lines, 0 to NUM_LINES |
| rx_set | input | NUM_LINES | Per-line receive request set pulses |
| rx_clr | input | NUM_LINES | Per-line receive request clear pulses |
| tx_set | input | NUM_LINES | Per-line transmit request set pulses |
| tx_clr | input | NUM_LINES | Per-line transmit request clear pulses |
| rx_ack | input | 1 | Receive class acknowledge |
| tx_ack | input | 1 | Transmit class acknowledge |
| rx_irq | output | 1 | Receive master request |
| tx_irq | output | 1 | Transmit master request |
| vec_out | output | VEC_W | Vector of the serviced line |
| vec_valid | output | 1 | vec_out holds a result this cycle |
| vec_is_tx | output | 1 | Shown vector belongs to the transmit class |

## Verification
The bench builds the block with its defaults: sixteen lines and a 9-bit vector. This puts the top line's transmit vector (base + 124) in range, and a high base makes it wrap past 2^9. Changing active_lines at run time brings the masking of upper lines within reach, using only the port. With both classes present, the bench can exercise simultaneous acknowledges and the ignored acknowledge in the waiting state.

// File: rtl/irq_vec_arbiter_pkg.sv
package irq_vec_arbiter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE            = 2'd0,
        ST_RX_SHOW         = 2'd1,
        ST_TX_SHOW         = 2'd2,
        ST_RX_SHOW_TX_WAIT = 2'd3
    } arb_state_t;

endpackage

// File: rtl/ivarb_req_bank.sv
module ivarb_req_bank #(
    parameter int NUM_LINES = 16,
    parameter int ACT_W     = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACT_W-1:0]     active_lines,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    input  logic [NUM_LINES-1:0] grant_i,
    input  logic                 take_i,
    output logic [NUM_LINES-1:0] live_o,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] enable_mask;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic drop;
        assign enable_mask[i] = (ACT_W'(i) < active_lines);
        assign drop           = clr_i[i] | (grant_i[i] & take_i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_q[i] <= 1'b1;
            end else if (drop) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

    assign live_o = pend_q & enable_mask;
    assign irq_o  = |live_o;

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    // R3
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && ((grant_i & set_i) == '0)) |=> ((pend_q & $past(grant_i)) == '0));

endmodule

// File: rtl/ivarb_prio_pick.sv
module ivarb_prio_pick #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req_i,
    output logic [NUM_LINES-1:0] grant_o,
    output logic [LINE_W-1:0]    line_o,
    output logic                 found_o
);

    always_comb begin
        grant_o = '0;
        line_o  = '0;
        found_o = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                line_o     = LINE_W'(i);
                found_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivarb_vec_fsm.sv
module ivarb_vec_fsm
    import irq_vec_arbiter_pkg::*;
#(
    parameter int LINE_W = 4,
    parameter int VEC_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  vec_base,
    input  logic              rx_ack_i,
    input  logic              tx_ack_i,
    input  logic              rx_found_i,
    input  logic [LINE_W-1:0] rx_line_i,
    input  logic              tx_found_i,
    input  logic [LINE_W-1:0] tx_line_i,
    output logic              rx_take_o,
    output logic              tx_take_o,
    output logic [VEC_W-1:0]  vec_out_o,
    output logic              vec_valid_o,
    output logic              vec_is_tx_o
);

    localparam int SPACE_SH = 3;

    arb_state_t state_q, state_d;
    logic [VEC_W-1:0] rx_vec, tx_vec, vec_q;

    assign rx_vec = rx_found_i ? (vec_base + VEC_W'({rx_line_i, 3'b000})) : '0;
    assign tx_vec = tx_found_i ? (vec_base + VEC_W'({tx_line_i, 3'b100})) : '0;

    always_comb begin
        state_d   = ST_IDLE;
        rx_take_o = 1'b0;
        tx_take_o = 1'b0;
        unique case (state_q)
            ST_RX_SHOW_TX_WAIT: begin
                state_d   = ST_TX_SHOW;
                tx_take_o = 1'b1;
            end
            ST_IDLE, ST_RX_SHOW, ST_TX_SHOW: begin
                if (rx_ack_i && tx_ack_i) begin
                    state_d   = ST_RX_SHOW_TX_WAIT;
                    rx_take_o = 1'b1;
                end else if (rx_ack_i) begin
                    state_d   = ST_RX_SHOW;
                    rx_take_o = 1'b1;
                end else if (tx_ack_i) begin
                    state_d   = ST_TX_SHOW;
                    tx_take_o = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (rx_take_o) begin
            vec_q <= rx_vec;
        end else if (tx_take_o) begin
            vec_q <= tx_vec;
        end
    end

    always_comb begin
        vec_out_o   = '0;
        vec_valid_o = 1'b0;
        vec_is_tx_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RX_SHOW, ST_RX_SHOW_TX_WAIT: begin
                vec_out_o   = vec_q;
                vec_valid_o = 1'b1;
            end
            ST_TX_SHOW: begin
                vec_out_o   = vec_q;
                vec_valid_o = 1'b1;
                vec_is_tx_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    queue_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_SHOW_TX_WAIT) |=> (state_q == ST_TX_SHOW));

    // R6
    ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_ack_i || tx_ack_i) && state_q != ST_RX_SHOW_TX_WAIT) |=> vec_valid_o);

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack_i && !rx_found_i && state_q != ST_RX_SHOW_TX_WAIT) |=> (vec_out_o == '0));

    // R4
    tx_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack_i && !rx_ack_i && tx_found_i && state_q != ST_RX_SHOW_TX_WAIT)
        |=> (vec_out_o[SPACE_SH-1:0] == $past(vec_base[SPACE_SH-1:0]) + 3'd4));

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 9,
    parameter int ACT_W     = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VEC_W-1:0]     vec_base,
    input  logic [ACT_W-1:0]     active_lines,
    input  logic [NUM_LINES-1:0] rx_set,
    input  logic [NUM_LINES-1:0] rx_clr,
    input  logic [NUM_LINES-1:0] tx_set,
    input  logic [NUM_LINES-1:0] tx_clr,
    input  logic                 rx_ack,
    input  logic                 tx_ack,
    output logic                 rx_irq,
    output logic                 tx_irq,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_valid,
    output logic                 vec_is_tx
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] rx_live, tx_live, rx_grant, tx_grant;
    logic [LINE_W-1:0]    rx_line, tx_line;
    logic                 rx_found, tx_found, rx_take, tx_take;

    ivarb_req_bank #(.NUM_LINES(NUM_LINES), .ACT_W(ACT_W)) u_rx_bank (
        .clk(clk), .rst_n(rst_n), .active_lines(active_lines),
        .set_i(rx_set), .clr_i(rx_clr), .grant_i(rx_grant), .take_i(rx_take),
        .live_o(rx_live), .irq_o(rx_irq)
    );

    ivarb_req_bank #(.NUM_LINES(NUM_LINES), .ACT_W(ACT_W)) u_tx_bank (
        .clk(clk), .rst_n(rst_n), .active_lines(active_lines),
        .set_i(tx_set), .clr_i(tx_clr), .grant_i(tx_grant), .take_i(tx_take),
        .live_o(tx_live), .irq_o(tx_irq)
    );

    ivarb_prio_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_rx_pick (
        .req_i(rx_live), .grant_o(rx_grant), .line_o(rx_line), .found_o(rx_found)
    );

    ivarb_prio_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_tx_pick (
        .req_i(tx_live), .grant_o(tx_grant), .line_o(tx_line), .found_o(tx_found)
    );

    ivarb_vec_fsm #(.LINE_W(LINE_W), .VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vec_base(vec_base),
        .rx_ack_i(rx_ack), .tx_ack_i(tx_ack),
        .rx_found_i(rx_found), .rx_line_i(rx_line),
        .tx_found_i(tx_found), .tx_line_i(tx_line),
        .rx_take_o(rx_take), .tx_take_o(tx_take),
        .vec_out_o(vec_out), .vec_valid_o(vec_valid), .vec_is_tx_o(vec_is_tx)
    );

    // R8
    rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_found |-> (ACT_W'(rx_line) < active_lines));

    // R8
    tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_found |-> (ACT_W'(tx_line) < active_lines));

endmodule

// File: tb/test_irq_vec_arbiter.sv
`timescale 1ns/1ps
module test_irq_vec_arbiter;

    localparam int N  = 16;
    localparam int VW = 9;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vec_base = 9'd64;
    logic [AW-1:0] active_lines = 5'd16;
    logic [N-1:0]  rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
    logic          rx_ack = 1'b0, tx_ack = 1'b0;
    logic          rx_irq, tx_irq, vec_valid, vec_is_tx;
    logic [VW-1:0] vec_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_arbiter #(.NUM_LINES(N), .VEC_W(VW)) i_irq_vec_arbiter (
        .clk(clk), .rst_n(rst_n), .vec_base(vec_base), .active_lines(active_lines),
        .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
        .rx_ack(rx_ack), .tx_ack(tx_ack), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .vec_out(vec_out), .vec_valid(vec_valid), .vec_is_tx(vec_is_tx)
    );

    // {is_tx, set mask, expected vector}, base 64
    localparam logic [25:0] TBL [8] = '{
        {1'b0, 16'h0005, 9'd64},
        {1'b0, 16'h0000, 9'd80},
        {1'b0, 16'h0000, 9'd0},
        {1'b1, 16'h8000, 9'd188},
        {1'b1, 16'h0030, 9'd100},
        {1'b1, 16'h0001, 9'd68},
        {1'b1, 16'h0000, 9'd108},
        {1'b0, 16'h0400, 9'd144}
    };

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_set(bit is_tx, logic [N-1:0] m);
        @(negedge clk);
        if (is_tx) tx_set = m; else rx_set = m;
        @(negedge clk);
        rx_set = '0; tx_set = '0;
    endtask

    task automatic do_ack(bit rx, bit tx);
        @(negedge clk);
        rx_ack = rx; tx_ack = tx;
        @(negedge clk);
        rx_ack = 1'b0; tx_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 rx_irq", rx_irq, 0);
        check("R9 tx_irq", tx_irq, 0);
        check("R9 vec_valid", vec_valid, 0);
        check("R9 vec_out", vec_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 R4 R5 R6
        for (int k = 0; k < 8; k++) begin
            pulse_set(TBL[k][25], TBL[k][24:9]);
            do_ack(!TBL[k][25], TBL[k][25]);
            check("R4 table vector", vec_out, TBL[k][8:0]);
            check("R6 table valid", vec_valid, 1);
            check("R6 table class", vec_is_tx, TBL[k][25]);
        end
        @(negedge clk);
        check("R6 valid drops", vec_valid, 0);
        check("R1 rx empty", rx_irq, 0);
        check("R1 tx empty", tx_irq, 0);

        // R1 stays high until all cleared
        pulse_set(1'b0, 16'h000A);
        check("R1 rx raised", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R3 line1", vec_out, 72);
        check("R1 still high", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R3 line3", vec_out, 88);
        check("R1 dropped", rx_irq, 0);

        // R2 set and clear in same cycle, set wins
        @(negedge clk);
        rx_set[6] = 1'b1; rx_clr[6] = 1'b1;
        @(negedge clk);
        rx_set = '0; rx_clr = '0;
        check("R2 set beats clr", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R2 line6 vector", vec_out, 112);
        // R2 clear removes
        pulse_set(1'b1, 16'h0080);
        check("R2 tx set", tx_irq, 1);
        @(negedge clk); tx_clr = 16'h0080;
        @(negedge clk); tx_clr = '0;
        check("R2 tx clr", tx_irq, 0);

        // R2 set beats acknowledge clearing the same bit
        pulse_set(1'b0, 16'h0004);
        @(negedge clk);
        rx_ack = 1'b1; rx_set = 16'h0004;
        @(negedge clk);
        rx_ack = 1'b0; rx_set = '0;
        check("R2 ack vector", vec_out, 80);
        check("R2 set beats ack", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R2 second ack", vec_out, 80);
        check("R2 cleared", rx_irq, 0);

        // R7 both acks, ignored ack while waiting
        pulse_set(1'b0, 16'h0012);
        pulse_set(1'b1, 16'h0008);
        @(negedge clk);
        rx_ack = 1'b1; tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
        check("R7 rx first", vec_out, 72);
        check("R7 rx class", vec_is_tx, 0);
        check("R7 rx valid", vec_valid, 1);
        @(negedge clk);
        rx_ack = 1'b0;
        check("R7 tx second", vec_out, 92);
        check("R7 tx class", vec_is_tx, 1);
        @(negedge clk);
        check("R7 ignored ack", vec_valid, 0);
        check("R7 line4 kept", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R7 line4 vector", vec_out, 96);

        // R8 masking
        active_lines = 5'd4;
        pulse_set(1'b0, 16'h0200);
        check("R8 masked irq", rx_irq, 0);
        do_ack(1'b1, 1'b0);
        check("R8 masked vector", vec_out, 0);
        check("R5 empty valid", vec_valid, 1);
        active_lines = 5'd16;
        @(negedge clk);
        check("R8 unmasked irq", rx_irq, 1);
        do_ack(1'b1, 1'b0);
        check("R8 line9 vector", vec_out, 136);

        // R4 wrap modulo 2^VEC_W
        vec_base = 9'd496;
        pulse_set(1'b1, 16'h0008);
        do_ack(1'b0, 1'b1);
        check("R4 wrap", vec_out, 12);

        // R5 transmit empty
        do_ack(1'b0, 1'b1);
        check("R5 tx empty", vec_out, 0);
        check("R5 tx empty class", vec_is_tx, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule